// File: doc/BRIEF.md
# Hotswap Switch Mode Controller

This block sequences the gate mode of a power switch that sits between the port return rail and the input capacitor of a downstream converter. An enable from the port sequencer starts it. Three analog comparators report the voltage drop across the switch: a flag for a drop below 380 mV, a flag for a drop below 360 mV, and a flag for a drop above 3.6 V. From these it picks one of four modes: switch open, current-limited charging of the input capacitor, switch fully on, or a low current limit after an overload.

The route into overload is filtered. The high-drop flag must stay set for a qualified time (140 µs) before the switch falls back to the low current limit. The route out of overload needs two things: the lower 360 mV threshold, and a minimum stay of 80 ms counted from the moment of entry. Both times are given in microseconds and are turned into clock counts at elaboration from the clock frequency parameter. All comparator flags pass through a two-flop synchroniser before the controller uses them. The enable is a synchronous on-chip signal and is used directly.

Top module: `hsw_ctrl`

## Requirements
- R1: During and right after reset, state_o is 0 (open state) and gate_o is 0 (switch open).
- R2: While en_i is low, the controller goes to state 0 with gate 0 at the next clock edge, whatever its current state and whatever the flags.
- R3: With en_i high in state 0, the next edge moves to state 1 (charging), and gate_o becomes 1 (inrush current limit), not the fully-on code.
- R4: In state 1, a set below-380 mV flag moves the controller to state 2 (fully on, gate code 2). The move happens on the third rising edge after the flag changes. While that flag is clear, the controller stays in state 1.
- R5: In state 2, the controller moves to state 3 (low current limit, gate code 3) only after the synchronised above-3.6 V flag has been set for PERSIST_CYC consecutive cycles. PERSIST_CYC is the ceiling of CLK_HZ·PERSIST_US/10^6. An input pulse that lasts exactly PERSIST_CYC cycles produces state 3 at edge PERSIST_CYC+2 after its start.
- R6: A drop of the above-3.6 V flag restarts the persistence count. Two pulses of PERSIST_CYC-1 cycles, separated by a one-cycle gap, leave the controller in state 2.
- R7: The controller leaves state 3 for state 2 only when the synchronised below-360 mV flag is set and at least DWELL_CYC cycles have passed in state 3. DWELL_CYC is the ceiling of CLK_HZ·DWELL_US/10^6. If the flag is already set at entry, state 3 lasts exactly DWELL_CYC cycles.
- R8: In state 3, the below-380 mV flag alone does not release the controller, even long after the dwell has elapsed. Once the dwell has elapsed, setting the below-360 mV flag releases it on the third edge.
- R9: The dwell count restarts at zero on every entry into state 3. A second overload after a short stay in state 2 again lasts exactly DWELL_CYC cycles.
- R10: gate_o follows the state with the codes open=0, inrush limit=1, fully on=2, low limit=3. The state codes are off=0, charging=1, on=2, overload=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, CLK_HZ |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Enable from port sequencer (low = undervoltage lockout) |
| drop_lo380_i | input | 1 | Asynchronous comparator: switch drop below 380 mV |
| drop_lo360_i | input | 1 | Asynchronous comparator: switch drop below 360 mV |
| drop_hi_i | input | 1 | Asynchronous comparator: switch drop above 3.6 V |
| gate_o | output | 2 | Gate mode code |
| state_o | output | 2 | Controller state code |

## Verification
The hardest situation to reach is the exact edge of each timed window. One case is a high-drop pulse that lasts exactly the persistence count. The other is a release request that meets the dwell boundary in its final cycle. Both are seen only through a two-cycle synchroniser. The bench uses a small clock frequency, so the windows shrink to 14 and 8000 cycles, and it computes those counts itself. It then sweeps every pulse length from one cycle up to the threshold, checking a cycle before and a cycle at each predicted transition. For the dwell, it holds the release flag set from the moment of entry, so the exit edge lands on the dwell count exactly. It does this for two separate entries.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_INRUSH = 2'd1,
    ST_ON     = 2'd2,
    ST_OVL    = 2'd3
  } hsw_state_t;

  typedef enum logic [1:0] {
    GM_OPEN     = 2'd0,
    GM_INRUSH   = 2'd1,
    GM_FULL     = 2'd2,
    GM_LOWLIMIT = 2'd3
  } hsw_gate_t;

  // Ceiling of hz*us/1e6, never less than one cycle.
  function automatic int unsigned us_to_cycles(input int unsigned hz, input int unsigned us);
    longint unsigned prod;
    longint unsigned q;
    prod = longint'(hz) * longint'(us);
    q    = (prod + 64'd999_999) / 64'd1_000_000;
    if (q == 0) q = 1;
    return int'(q);
  endfunction

  function automatic hsw_gate_t gate_of(input hsw_state_t s);
    case (s)
      ST_INRUSH: return GM_INRUSH;
      ST_ON:     return GM_FULL;
      ST_OVL:    return GM_LOWLIMIT;
      default:   return GM_OPEN;
    endcase
  endfunction

endpackage

// File: rtl/hsw_sync.sv
module hsw_sync #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic meta_q;
    logic stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= async_i[b];
        stab_q <= meta_q;
      end
    end
    assign sync_o[b] = stab_q;
  end
endmodule

// File: rtl/hsw_qual_timer.sv
// Counts consecutive cycles of (arm && cond); fires in the TC-th such cycle.
module hsw_qual_timer #(
  parameter int unsigned TC = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic cond_i,
  output logic fire_o
);
  localparam int unsigned W = (TC < 2) ? 1 : $clog2(TC + 1);
  localparam logic [W-1:0] LAST = W'(TC - 1);

  logic [W-1:0] cnt_q;
  logic         run;

  assign run    = arm_i && cond_i;
  assign fire_o = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run)         cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/hsw_dwell_timer.sv
// Cleared while idle; counts cycles while running and saturates at TC-1.
module hsw_dwell_timer #(
  parameter int unsigned TC = 8000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic met_o
);
  localparam int unsigned W = (TC < 2) ? 1 : $clog2(TC + 1);
  localparam logic [W-1:0] LAST = W'(TC - 1);

  logic [W-1:0] cnt_q;

  assign met_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run_i)        cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/hsw_fsm.sv
module hsw_fsm
  import hsw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       lo380_i,
  input  logic       lo360_i,
  input  logic       ovl_fire_i,
  input  logic       dwell_met_i,
  output hsw_state_t state_o
);
  hsw_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!en_i) begin
      state_d = ST_OFF;
    end else begin
      case (state_q)
        ST_OFF:    state_d = ST_INRUSH;
        ST_INRUSH: if (lo380_i) state_d = ST_ON;
        ST_ON:     if (ovl_fire_i) state_d = ST_OVL;
        ST_OVL:    if (lo360_i && dwell_met_i) state_d = ST_ON;
        default:   state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/hsw_ctrl.sv
module hsw_ctrl
  import hsw_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned PERSIST_US = 140,
  parameter int unsigned DWELL_US   = 80_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       drop_lo380_i,
  input  logic       drop_lo360_i,
  input  logic       drop_hi_i,
  output logic [1:0] gate_o,
  output logic [1:0] state_o
);
  localparam int unsigned PERSIST_CYC = us_to_cycles(CLK_HZ, PERSIST_US);
  localparam int unsigned DWELL_CYC   = us_to_cycles(CLK_HZ, DWELL_US);

  logic [2:0] flags_s;
  logic       lo380_s, lo360_s, hi_s;
  logic       persist_fire;
  logic       dwell_met;
  hsw_state_t st;

  hsw_sync #(.N(3)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i({drop_hi_i, drop_lo360_i, drop_lo380_i}),
    .sync_o (flags_s)
  );

  assign lo380_s = flags_s[0];
  assign lo360_s = flags_s[1];
  assign hi_s    = flags_s[2];

  hsw_qual_timer #(.TC(PERSIST_CYC)) u_persist (
    .clk   (clk),
    .rst_n (rst_n),
    .arm_i (st == ST_ON),
    .cond_i(hi_s),
    .fire_o(persist_fire)
  );

  hsw_dwell_timer #(.TC(DWELL_CYC)) u_dwell (
    .clk  (clk),
    .rst_n(rst_n),
    .run_i(st == ST_OVL),
    .met_o(dwell_met)
  );

  hsw_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .lo380_i    (lo380_s),
    .lo360_i    (lo360_s),
    .ovl_fire_i (persist_fire),
    .dwell_met_i(dwell_met),
    .state_o    (st)
  );

  assign state_o = st;
  assign gate_o  = gate_of(st);
endmodule

// File: rtl/hsw_ctrl_chk.sv
module hsw_ctrl_chk
  import hsw_pkg::*;
#(
  parameter int unsigned PERSIST_CYC = 14,
  parameter int unsigned DWELL_CYC   = 8000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic [1:0] st,
  input logic [1:0] gate,
  input logic       hi_s,
  input logic       lo380_s,
  input logic       lo360_s,
  input logic       persist_fire,
  input logic       dwell_met
);
  localparam int unsigned W = $clog2(PERSIST_CYC + DWELL_CYC + 2);

  logic [W-1:0] hi_run;
  logic [W-1:0] ovl_cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run  <= '0;
      ovl_cyc <= '0;
    end else begin
      if (st == ST_ON && hi_s) begin
        if (hi_run != W'(PERSIST_CYC)) hi_run <= hi_run + 1'b1;
      end else begin
        hi_run <= '0;
      end
      if (st == ST_OVL) begin
        if (ovl_cyc != W'(DWELL_CYC)) ovl_cyc <= ovl_cyc + 1'b1;
      end else begin
        ovl_cyc <= '0;
      end
    end
  end

  AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (st == ST_OFF && gate == GM_OPEN)); // R2

  AST_ENABLE_ENTERS_INRUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OFF && en) |=> (st == ST_INRUSH && gate == GM_INRUSH)); // R3

  AST_INRUSH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_INRUSH && en && lo380_s) |=> st == ST_ON); // R4

  AST_INRUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_INRUSH && en && !lo380_s) |=> st == ST_INRUSH); // R4

  AST_ON_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ON && en && !persist_fire) |=> st == ST_ON); // R5

  AST_OVL_ENTRY_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OVL && $past(st) == ST_ON) |-> ($past(hi_run) >= W'(PERSIST_CYC - 1))); // R5

  AST_OVL_EXIT_THRESHOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ON && $past(st) == ST_OVL) |-> $past(lo360_s)); // R7

  AST_OVL_MIN_DWELL: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ON && $past(st) == ST_OVL) |-> ($past(ovl_cyc) >= W'(DWELL_CYC - 1))); // R7

  AST_DWELL_FLAG_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    dwell_met |-> (st == ST_OVL && ovl_cyc >= W'(DWELL_CYC - 1))); // R9

  AST_GATE_OPEN_IN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OFF) |-> (gate == GM_OPEN)); // R10
endmodule

bind hsw_ctrl hsw_ctrl_chk #(
  .PERSIST_CYC(PERSIST_CYC),
  .DWELL_CYC  (DWELL_CYC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en          (en_i),
  .st          (state_o),
  .gate        (gate_o),
  .hi_s        (hi_s),
  .lo380_s     (lo380_s),
  .lo360_s     (lo360_s),
  .persist_fire(persist_fire),
  .dwell_met   (dwell_met)
);

// File: tb/sim_hsw_ctrl.sv
`timescale 1ns/1ps
module sim_hsw_ctrl;
  localparam int unsigned HZ  = 100_000;
  localparam int unsigned PUS = 140;
  localparam int unsigned DUS = 80_000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       lo380 = 1'b0;
  logic       lo360 = 1'b0;
  logic       hi = 1'b0;
  logic [1:0] gate;
  logic [1:0] st;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int pc;
  int dc;

  always #2 clk = ~clk;

  hsw_ctrl #(.CLK_HZ(HZ), .PERSIST_US(PUS), .DWELL_US(DUS)) u0 (
    .clk(clk), .rst_n(rst_n), .en_i(en),
    .drop_lo380_i(lo380), .drop_lo360_i(lo360), .drop_hi_i(hi),
    .gate_o(gate), .state_o(st)
  );

  function automatic int ceil_cycles(input longint hz, input longint us);
    longint p = hz * us;
    longint q = p / 1_000_000;
    if (q * 1_000_000 < p) q = q + 1;
    return int'(q);
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [1:0] exp_st);
    logic [1:0] exp_g;
    exp_g = exp_st;  // R10: gate code equals state code
    total++;
    if (st !== exp_st || gate !== exp_g) begin
      bad++;
      $display("FAIL %s: state=%0d gate=%0d expected state=%0d gate=%0d", req, st, gate, exp_st, exp_g);
    end
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    pc = ceil_cycles(HZ, PUS);
    dc = ceil_cycles(HZ, DUS);
    step(3);
    check("R1 in reset", 2'd0);
    rst_n = 1'b1;
    step(2);
    check("R1 after reset", 2'd0);

    // R2: disabled with every flag pattern stays open
    for (int f = 0; f < 8; f++) begin
      {hi, lo360, lo380} = 3'(f);
      step(4);
      check("R2 disabled flags", 2'd0);
    end
    {hi, lo360, lo380} = 3'b000;
    step(3);

    // R3
    en = 1'b1;
    step(1);
    check("R3 enable to inrush", 2'd1);
    hi = 1'b1; lo360 = 1'b1;
    step(6);
    check("R4 no lo380 holds inrush", 2'd1);
    hi = 1'b0; lo360 = 1'b0;
    step(3);

    // R4: three edges latency through synchroniser
    lo380 = 1'b1;
    step(2);
    check("R4 before sync latency", 2'd1);
    step(1);
    check("R4 inrush to on", 2'd2);

    // R5: sweep of short pulses
    for (int len = 1; len < pc; len++) begin
      hi = 1'b1; step(len); hi = 1'b0; step(4);
      check("R5 short pulse stays on", 2'd2);
    end
    // R6: split pulses
    hi = 1'b1; step(pc - 1); hi = 1'b0; step(1); hi = 1'b1; step(pc - 1); hi = 1'b0;
    step(4);
    check("R6 restart on dropout", 2'd2);

    // R5: exact-length pulse
    hi = 1'b1; step(pc); hi = 1'b0;
    step(1);
    check("R5 edge pc+1 still on", 2'd2);
    step(1);
    check("R5 edge pc+2 overload", 2'd3);

    // R8: lo380 alone never releases
    lo380 = 1'b1; lo360 = 1'b0;
    step(dc + 20);
    check("R8 lo380 alone holds overload", 2'd3);
    lo360 = 1'b1;
    step(2);
    check("R8 before sync latency", 2'd3);
    step(1);
    check("R8 release after dwell", 2'd2);

    // R7 and R9: second entry, lo360 held from entry, exact dwell
    step(3);
    hi = 1'b1; step(pc + 2);
    check("R9 re-enter overload", 2'd3);
    hi = 1'b0;
    step(dc - 1);
    check("R7 one cycle before dwell", 2'd3);
    step(1);
    check("R7 exit at dwell", 2'd2);

    // R2: enable drop from each active state
    lo380 = 1'b0; lo360 = 1'b0;
    en = 1'b0; step(1);
    check("R2 on to off", 2'd0);
    en = 1'b1; step(1);
    check("R3 re-enable inrush", 2'd1);
    en = 1'b0; step(1);
    check("R2 inrush to off", 2'd0);
    en = 1'b1; lo380 = 1'b1; step(4);
    check("R4 on again", 2'd2);
    hi = 1'b1; step(pc + 2);
    check("R5 overload again", 2'd3);
    en = 1'b0; step(1);
    check("R2 overload to off", 2'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule